// File: doc/BRIEF.md
# SCSI Initiator Register Core

This block is the host-facing register file of a simple SCSI initiator controller. A CPU reaches it one byte at a time: it writes at a register index with `wr_en`, and it reads at an index with `rd_en`. The read data is combinational from the current state. The side effects of a read take place at the clock edge that ends the read cycle. The block keeps a write-side image for the transfer count and a separate counter that software can read back. It also holds a configuration byte, the last accepted command byte and a byte FIFO. On the read side it shows status, interrupt-cause and sequence-step registers, and it drives one level interrupt line.

Command bytes written to the command index are decoded here. Housekeeping commands update status, cause and sequence step directly. Commands that select a target or move data are only handed on: a one-cycle strobe, together with the opcode and the DMA flag, goes to the bus-phase engine. That engine reports completion on `stub_done`. Software acknowledges an interrupt by reading the interrupt-cause register.

Register indices: 0 count low, 1 count middle, 2 FIFO, 3 command, 4 status, 5 interrupt cause, 6 sequence step, 7 FIFO flags (pending byte count), 8 configuration 1, 9 count high (reads the chip identity). Writes are accepted at indices 0, 1, 2, 3 and 8. A write to any other index is ignored. A read of an unused index returns 0.

Top module: `scsi_regcore`

## Requirements
- R1: After reset, all of the following read 0: status, interrupt cause, sequence step, FIFO flags, the readable counter and the command readback. Configuration 1 reads 0x07, index 9 reads `CHIP_ID`, and `irq` and `cmd_go` are low. Status bits 2:0 (phase) always read 0.
- R2: `irq` always equals status bit 7. Raising the interrupt while it is already raised leaves it high and changes nothing else. The interrupt drops only through the acknowledge read described in R3.
- R3: A read of index 5 returns the interrupt cause as it stood before the read. On the following cycle the cause is 0, status bit 4 (terminal count) is 0, the sequence step is 4, and `irq` is low.
- R4: Writes to index 0 or 1 change only the write-side count image, and they clear status bit 4. The readable counter at indices 0 and 1 takes the image values only when a recognised command byte is written with bit 7 (the DMA flag) set.
- R5: Command 0x01 (flush) sets the cause to 0x08, the sequence step to 0 and the FIFO flags to 0 (the FIFO is emptied), and it raises `irq`.
- R6: Command 0x03 (bus reset) sets the cause to 0x80. It raises `irq` only when configuration 1 bit 6 (reset report disable) is 0.
- R7: Command 0x12 (message accepted) sets the cause to 0x20, the sequence step to 0 and the FIFO flags to 0, and it raises `irq`. Commands 0x44 and 0x45 (enable and disable selection) clear the cause and leave `irq` unchanged.
- R8: Commands 0x10 (transfer), 0x41 (select) and 0x42 (select with attention) pulse `cmd_go` for exactly one cycle, on the cycle after the write. During that pulse, `cmd_go_op` carries bits 6:0 of the command byte and `cmd_go_dma` carries bit 7. These commands change no cause, status or sequence-step value.
- R9: A command byte whose bits 6:0 are not one of 0x00, 0x01, 0x03, 0x10, 0x12, 0x41, 0x42, 0x44 or 0x45 changes no state. It does not reload the counter, does not update the command readback, does not change the cause and does not strobe `cmd_go`.
- R10: A write to index 2 appends the byte to the FIFO, unless the FIFO already holds `FIFO_DEPTH`-1 bytes, in which case the byte is dropped. A read of index 2 returns the oldest byte and removes it. Reading an empty FIFO returns 0 and changes nothing. Index 7 reads the number of pending bytes.
- R11: A cycle with `stub_done` high sets status bit 4, sets the cause to 0x10 (bus service) and the sequence step to 0, and raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (triggers read side effects) |
| addr | input | 4 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, equal to status bit 7 |
| stub_done | input | 1 | Completion report from the bus-phase engine |
| cmd_go | output | 1 | One-cycle strobe for selection and transfer commands |
| cmd_go_op | output | 7 | Opcode handed to the bus-phase engine |
| cmd_go_dma | output | 1 | DMA flag handed to the bus-phase engine |

## Verification
On every cycle, the assertions cover several properties. The acknowledge read always leaves the line low with cause 0 and step 4. Count-image writes never disturb the readable counter. A suppressed bus reset never raises the line. The FIFO never exceeds one less than its depth. An unknown opcode never strobes the engine, and every strobe traces back to a command write. The bench scenarios cover the properties that depend on values and history: the old value returned by the acknowledge read, the reload contents, FIFO byte order and the drop on overrun, and the exact cause codes. A seeded random mix of writes, reads, commands and completions, compared against a behavioural scoreboard, shows that these hold across interleavings.

// File: rtl/scsi_regcore_pkg.sv
package scsi_regcore_pkg;

    // register indices
    localparam logic [3:0] REG_CNT_LO  = 4'd0;
    localparam logic [3:0] REG_CNT_MID = 4'd1;
    localparam logic [3:0] REG_FIFO    = 4'd2;
    localparam logic [3:0] REG_CMD     = 4'd3;
    localparam logic [3:0] REG_STAT    = 4'd4;
    localparam logic [3:0] REG_CAUSE   = 4'd5;
    localparam logic [3:0] REG_SEQ     = 4'd6;
    localparam logic [3:0] REG_FLAGS   = 4'd7;
    localparam logic [3:0] REG_CFG1    = 4'd8;
    localparam logic [3:0] REG_CNT_HI  = 4'd9;

    // opcodes (command byte bits 6:0)
    localparam logic [6:0] OP_NOP        = 7'h00;
    localparam logic [6:0] OP_FLUSH      = 7'h01;
    localparam logic [6:0] OP_BUS_RESET  = 7'h03;
    localparam logic [6:0] OP_XFER       = 7'h10;
    localparam logic [6:0] OP_MSG_ACC    = 7'h12;
    localparam logic [6:0] OP_SELECT     = 7'h41;
    localparam logic [6:0] OP_SELECT_ATN = 7'h42;
    localparam logic [6:0] OP_SEL_EN     = 7'h44;
    localparam logic [6:0] OP_SEL_DIS    = 7'h45;

    // interrupt cause codes
    localparam logic [7:0] CAUSE_RESET = 8'h80;
    localparam logic [7:0] CAUSE_DISC  = 8'h20;
    localparam logic [7:0] CAUSE_BSVC  = 8'h10;
    localparam logic [7:0] CAUSE_FDONE = 8'h08;

    localparam logic [2:0] SEQ_DONE        = 3'd4;
    localparam int         CFG1_NOREPORT_B = 6;
    localparam logic [7:0] CFG1_RESET_VAL  = 8'h07;

    typedef enum logic [1:0] {
        IRQ_KEEP,
        IRQ_RAISE,
        IRQ_RAISE_IF_REPORT
    } irq_act_e;

    typedef struct packed {
        logic       valid;
        logic       cause_we;
        logic [7:0] cause_val;
        logic       seq_clr;
        logic       fifo_clr;
        irq_act_e   irq;
        logic       stub;
    } cmd_action_t;

    function automatic logic [7:0] pack_status(input logic int_f, input logic tc);
        return {int_f, 2'b00, tc, 1'b0, 3'b000};
    endfunction

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
    import scsi_regcore_pkg::*;
(
    input  logic [6:0]  op,
    output cmd_action_t act
);
    always_comb begin
        act.valid     = 1'b1;
        act.cause_we  = 1'b0;
        act.cause_val = 8'h00;
        act.seq_clr   = 1'b0;
        act.fifo_clr  = 1'b0;
        act.irq       = IRQ_KEEP;
        act.stub      = 1'b0;
        case (op)
            OP_NOP: ;
            OP_FLUSH: begin
                act.cause_we  = 1'b1;
                act.cause_val = CAUSE_FDONE;
                act.seq_clr   = 1'b1;
                act.fifo_clr  = 1'b1;
                act.irq       = IRQ_RAISE;
            end
            OP_BUS_RESET: begin
                act.cause_we  = 1'b1;
                act.cause_val = CAUSE_RESET;
                act.irq       = IRQ_RAISE_IF_REPORT;
            end
            OP_MSG_ACC: begin
                act.cause_we  = 1'b1;
                act.cause_val = CAUSE_DISC;
                act.seq_clr   = 1'b1;
                act.fifo_clr  = 1'b1;
                act.irq       = IRQ_RAISE;
            end
            OP_SEL_EN, OP_SEL_DIS: begin
                act.cause_we  = 1'b1;
                act.cause_val = 8'h00;
            end
            OP_XFER, OP_SELECT, OP_SELECT_ATN: act.stub = 1'b1;
            default: act.valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [7:0]                   din,
    input  logic                         pop,
    output logic [7:0]                   dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wptr, rptr, wptr_nx, rptr_nx;
    logic          push_ok, pop_ok;

    assign push_ok = push && (count != LIMIT);
    assign pop_ok  = pop && (count != '0);
    assign dout    = (count != '0) ? mem[rptr] : 8'h00;

    generate
        if ((1 << PW) == DEPTH) begin : g_pow2_wrap
            assign wptr_nx = wptr + 1'b1;
            assign rptr_nx = rptr + 1'b1;
        end else begin : g_cmp_wrap
            assign wptr_nx = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            assign rptr_nx = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr_nx;
            if (pop_ok)  rptr <= rptr_nx;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R10
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= LIMIT);

    // R10
    fifo_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !clr && count == LIMIT) |=> (count == LIMIT));
endmodule

// File: rtl/scsi_regcore.sv
module scsi_regcore
    import scsi_regcore_pkg::*;
#(
    parameter int         FIFO_DEPTH = 16,
    parameter logic [7:0] CHIP_ID    = 8'hA2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    input  logic       stub_done,
    output logic       cmd_go,
    output logic [6:0] cmd_go_op,
    output logic       cmd_go_dma
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [7:0]  cnt_lo_w, cnt_mid_w, cfg1_w, cmd_w;
    logic [7:0]  cnt_lo_r, cnt_mid_r, cause;
    logic [2:0]  seq;
    logic        tc, int_f;
    logic [7:0]  fifo_out;
    logic [CW-1:0] fifo_cnt;
    cmd_action_t act;
    logic        cmd_wr, cmd_ok, raise_cmd, ack_rd;

    scsi_cmd_decode u_dec (
        .op  (wdata[6:0]),
        .act (act)
    );

    assign cmd_wr    = wr_en && (addr == REG_CMD);
    assign cmd_ok    = cmd_wr && act.valid;
    assign ack_rd    = rd_en && (addr == REG_CAUSE);
    assign raise_cmd = (act.irq == IRQ_RAISE) ||
                       ((act.irq == IRQ_RAISE_IF_REPORT) && !cfg1_w[CFG1_NOREPORT_B]);

    scsi_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (cmd_ok && act.fifo_clr),
        .push  (wr_en && (addr == REG_FIFO)),
        .din   (wdata),
        .pop   (rd_en && (addr == REG_FIFO)),
        .dout  (fifo_out),
        .count (fifo_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_lo_w   <= '0;
            cnt_mid_w  <= '0;
            cfg1_w     <= CFG1_RESET_VAL;
            cmd_w      <= '0;
            cnt_lo_r   <= '0;
            cnt_mid_r  <= '0;
            cause      <= '0;
            seq        <= '0;
            tc         <= 1'b0;
            int_f      <= 1'b0;
            cmd_go     <= 1'b0;
            cmd_go_op  <= '0;
            cmd_go_dma <= 1'b0;
        end else begin
            cmd_go <= 1'b0;
            if (wr_en) begin
                case (addr)
                    REG_CNT_LO:  begin cnt_lo_w  <= wdata; tc <= 1'b0; end
                    REG_CNT_MID: begin cnt_mid_w <= wdata; tc <= 1'b0; end
                    REG_CFG1:    cfg1_w <= wdata;
                    default: ;
                endcase
            end
            if (cmd_ok) begin
                cmd_w <= wdata;
                if (wdata[7]) begin
                    cnt_lo_r  <= cnt_lo_w;
                    cnt_mid_r <= cnt_mid_w;
                end
                if (act.cause_we) cause <= act.cause_val;
                if (act.seq_clr)  seq   <= '0;
                if (raise_cmd)    int_f <= 1'b1;
                if (act.stub) begin
                    cmd_go     <= 1'b1;
                    cmd_go_op  <= wdata[6:0];
                    cmd_go_dma <= wdata[7];
                end
            end
            if (stub_done) begin
                tc    <= 1'b1;
                cause <= CAUSE_BSVC;
                seq   <= '0;
                int_f <= 1'b1;
            end
            // acknowledge read has the last word
            if (ack_rd) begin
                cause <= '0;
                tc    <= 1'b0;
                seq   <= SEQ_DONE;
                int_f <= 1'b0;
            end
        end
    end

    assign irq = int_f;

    always_comb begin
        case (addr)
            REG_CNT_LO:  rdata = cnt_lo_r;
            REG_CNT_MID: rdata = cnt_mid_r;
            REG_FIFO:    rdata = fifo_out;
            REG_CMD:     rdata = cmd_w;
            REG_STAT:    rdata = pack_status(int_f, tc);
            REG_CAUSE:   rdata = cause;
            REG_SEQ:     rdata = {5'b0, seq};
            REG_FLAGS:   rdata = 8'(fifo_cnt);
            REG_CFG1:    rdata = cfg1_w;
            REG_CNT_HI:  rdata = CHIP_ID;
            default:     rdata = 8'h00;
        endcase
    end

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ack_rd |=> (!irq && cause == 8'h00 && seq == SEQ_DONE));

    // R4
    count_image_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == REG_CNT_LO || addr == REG_CNT_MID))
        |=> $stable({cnt_lo_r, cnt_mid_r}));

    // R6
    busrst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[6:0] == OP_BUS_RESET && cfg1_w[CFG1_NOREPORT_B]
         && !int_f && !stub_done) |=> !irq);

    // R8
    go_source_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_go |-> $past(cmd_wr));

    // R9
    unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !act.valid && !stub_done && !rd_en)
        |=> (!cmd_go && $stable(cause) && $stable(cmd_w)));
endmodule

// File: tb/scsi_regcore_tb.sv
`timescale 1ns/1ps
module scsi_regcore_tb_top;
    localparam int         DEPTH = 16;
    localparam logic [7:0] CHIP  = 8'hA2;

    logic clk = 1'b0;
    logic rst, wr_en, rd_en, stub_done;
    logic [3:0] addr;
    logic [7:0] wdata, rdata;
    logic irq, cmd_go, cmd_go_dma;
    logic [6:0] cmd_go_op;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    scsi_regcore #(.FIFO_DEPTH(DEPTH), .CHIP_ID(CHIP)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .stub_done(stub_done),
        .cmd_go(cmd_go), .cmd_go_op(cmd_go_op), .cmd_go_dma(cmd_go_dma)
    );

    // scoreboard
    logic [7:0] m_wlo, m_wmid, m_rlo, m_rmid, m_cfg1, m_cmd, m_cause;
    logic       m_tc, m_int;
    logic [2:0] m_seq;
    logic [7:0] m_q[$];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_wlo = 0; m_wmid = 0; m_rlo = 0; m_rmid = 0; m_cfg1 = 8'h07;
        m_cmd = 0; m_cause = 0; m_tc = 0; m_int = 0; m_seq = 0;
        m_q.delete();
    endtask

    function automatic bit op_known(input logic [6:0] op);
        return op inside {7'h00, 7'h01, 7'h03, 7'h10, 7'h12, 7'h41, 7'h42, 7'h44, 7'h45};
    endfunction

    function automatic bit op_stub(input logic [6:0] op);
        return op inside {7'h10, 7'h41, 7'h42};
    endfunction

    function automatic logic [7:0] exp_reg(input logic [3:0] a);
        case (a)
            4'd0: return m_rlo;
            4'd1: return m_rmid;
            4'd2: return (m_q.size() > 0) ? m_q[0] : 8'h00;
            4'd3: return m_cmd;
            4'd4: return {m_int, 2'b00, m_tc, 4'b0000};
            4'd5: return m_cause;
            4'd6: return {5'b0, m_seq};
            4'd7: return 8'(m_q.size());
            4'd8: return m_cfg1;
            4'd9: return CHIP;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd1: return "R4";
            4'd2, 4'd7: return "R10";
            4'd3:       return "R9";
            4'd9:       return "R1";
            default:    return "R3";
        endcase
    endfunction

    task automatic model_cmd(input logic [7:0] d);
        logic [6:0] op;
        op = d[6:0];
        if (!op_known(op)) return;
        m_cmd = d;
        if (d[7]) begin m_rlo = m_wlo; m_rmid = m_wmid; end
        case (op)
            7'h01: begin m_cause = 8'h08; m_seq = 0; m_q.delete(); m_int = 1; end
            7'h03: begin m_cause = 8'h80; if (!m_cfg1[6]) m_int = 1; end
            7'h12: begin m_cause = 8'h20; m_seq = 0; m_q.delete(); m_int = 1; end
            7'h44, 7'h45: m_cause = 8'h00;
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
        case (a)
            4'd0: begin m_wlo = d; m_tc = 0; end
            4'd1: begin m_wmid = d; m_tc = 0; end
            4'd2: if (m_q.size() != DEPTH - 1) m_q.push_back(d);
            4'd3: model_cmd(d);
            4'd8: m_cfg1 = d;
            default: ;
        endcase
    endtask

    // command write, with strobe check at the cycle after the write (R8/R9)
    task automatic do_cmd(input logic [7:0] d);
        bit exp_go;
        exp_go = op_stub(d[6:0]);
        bus_write(4'd3, d);
        chk(exp_go ? "R8 go" : "R9 no-go", {7'b0, cmd_go}, {7'b0, exp_go});
        if (exp_go) begin
            chk("R8 op", {1'b0, cmd_go_op}, {1'b0, d[6:0]});
            chk("R8 dma", {7'b0, cmd_go_dma}, {7'b0, d[7]});
            @(negedge clk);
            chk("R8 pulse width", {7'b0, cmd_go}, 8'h00);
        end
    endtask

    task automatic bus_read(input logic [3:0] a, input string tag);
        logic [7:0] e;
        e = exp_reg(a);
        @(negedge clk);
        rd_en = 1; addr = a;
        #1 chk(tag, rdata, e);
        @(negedge clk);
        rd_en = 0;
        if (a == 4'd2 && m_q.size() > 0) void'(m_q.pop_front());
        if (a == 4'd5) begin m_cause = 0; m_tc = 0; m_seq = 3'd4; m_int = 0; end
    endtask

    task automatic pulse_done();
        @(negedge clk);
        stub_done = 1;
        @(negedge clk);
        stub_done = 0;
        m_tc = 1; m_cause = 8'h10; m_seq = 0; m_int = 1;
    endtask

    task automatic chk_irq(input string tag);
        chk(tag, {7'b0, irq}, {7'b0, m_int});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1357;
        void'($urandom(seed));
        rst = 1; wr_en = 0; rd_en = 0; stub_done = 0; addr = 0; wdata = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        for (int a = 0; a < 10; a++) bus_read(4'(a), "R1 reset");
        chk_irq("R1 irq");
        chk("R1 go", {7'b0, cmd_go}, 8'h00);
        // (index 5 read above set step 4; re-check reset of phase bits)
        bus_read(4'd4, "R1 phase");

        // R4 count image vs readable counter
        bus_write(4'd0, 8'h34);
        bus_write(4'd1, 8'h12);
        bus_read(4'd0, "R4 no reload lo");
        bus_read(4'd1, "R4 no reload mid");
        do_cmd(8'h80);
        bus_read(4'd0, "R4 reload lo");
        bus_read(4'd1, "R4 reload mid");
        bus_write(4'd0, 8'h55);
        do_cmd(8'h00);
        bus_read(4'd0, "R4 no dma no reload");

        // R11 completion, R3 acknowledge
        pulse_done();
        chk_irq("R11 irq");
        bus_read(4'd4, "R11 status");
        bus_read(4'd6, "R11 seq");
        bus_read(4'd5, "R3 old cause");
        chk_irq("R3 irq low");
        bus_read(4'd5, "R3 cause cleared");
        bus_read(4'd4, "R3 status");
        bus_read(4'd6, "R3 seq step");

        // R4 terminal count cleared by count write, R2 irq kept
        pulse_done();
        bus_write(4'd1, 8'h01);
        bus_read(4'd4, "R4 tc clear");
        chk_irq("R2 irq held");
        pulse_done();
        chk_irq("R2 raise twice");
        bus_read(4'd5, "R3 ack");

        // R10 fill past capacity then drain
        for (int i = 0; i < 20; i++) bus_write(4'd2, 8'(8'hA0 + i));
        bus_read(4'd7, "R10 full count");
        for (int i = 0; i < DEPTH; i++) bus_read(4'd2, "R10 drain");
        bus_read(4'd7, "R10 empty count");

        // R5 flush
        for (int i = 0; i < 3; i++) bus_write(4'd2, 8'(i + 1));
        do_cmd(8'h01);
        chk_irq("R5 irq");
        bus_read(4'd7, "R5 flags");
        bus_read(4'd6, "R5 seq");
        bus_read(4'd5, "R5 cause");

        // R6 bus reset with report disabled then enabled
        bus_write(4'd8, 8'h47);
        do_cmd(8'h03);
        chk_irq("R6 suppressed");
        bus_read(4'd5, "R6 cause");
        bus_write(4'd8, 8'h07);
        do_cmd(8'h03);
        chk_irq("R6 reported");
        bus_read(4'd5, "R6 cause2");

        // R7 message accepted, selection enable/disable
        bus_write(4'd2, 8'h99);
        do_cmd(8'h12);
        chk_irq("R7 irq");
        bus_read(4'd7, "R7 flags");
        bus_read(4'd6, "R7 seq");
        do_cmd(8'h44);
        chk_irq("R7 irq unchanged");
        bus_read(4'd5, "R7 cause cleared");
        pulse_done();
        do_cmd(8'h45);
        chk_irq("R7 irq unchanged dis");
        bus_read(4'd5, "R7 cause cleared dis");

        // R8 stub commands
        pulse_done();
        do_cmd(8'hC1);
        do_cmd(8'h42);
        do_cmd(8'h10);
        bus_read(4'd4, "R8 status kept");
        bus_read(4'd5, "R8 cause kept");

        // R9 unknown opcode
        bus_write(4'd0, 8'hEE);
        do_cmd(8'hFF);
        do_cmd(8'h27);
        bus_read(4'd0, "R9 no reload");
        bus_read(4'd3, "R9 cmd readback");

        // constrained random mix against the scoreboard
        for (int n = 0; n < 600; n++) begin
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: bus_write(4'($urandom_range(0, 1)), 8'($urandom));
                1, 2: bus_write(4'd2, 8'($urandom));
                3: bus_read(4'd2, "R10 rnd");
                4: begin
                    logic [7:0] pick [10];
                    pick = '{8'h00, 8'h01, 8'h03, 8'h10, 8'h12, 8'h41, 8'h42, 8'h44, 8'h45, 8'h3A};
                    do_cmd({1'($urandom), pick[$urandom_range(0, 9)][6:0]});
                end
                5: bus_write(4'd8, {1'b0, 1'($urandom), 6'h07});
                6: pulse_done();
                default: begin
                    logic [3:0] a;
                    a = 4'($urandom_range(0, 11));
                    bus_read(a, tag_of(a));
                end
            endcase
            chk_irq("R2 rnd");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule